// File: doc/BRIEF.md
# Scan-Based Upset Test Controller

This block runs a complete upset test over a small functional register set whose flip-flops are all mux-D scan cells joined into one chain. A start command launches a run. The run first establishes a known starting state. That state comes either from the functional reset value or from a custom pattern fed in serially through the chain. The controller then opens a window of a programmable number of functional clock cycles. After the window it stops the functional clock for one idle cycle. It then shifts the whole chain out and compares each bit with a supplied expected image.

The functional logic inside the chain is a binary up-counter. Cell 0 is the least significant bit and is also the cell nearest scan-out. After a run, the outside world receives the number of mismatching bits and the chain index of the lowest failing bit. During unload the raw serial stream is also visible, so a test host can log the captured state itself. A window length of zero moves straight from load to unload, which checks that load and unload are exact inverses.

Top module: `scan_upset_ctrl`

## Requirements
- R1: After reset, busy, done, pat_take and so_valid are low, and mis_count and first_fail are zero.
- R2: With mode_custom low, the chain starts from the parameter value RESET_VAL.
- R3: With mode_custom high, pat_take is high for exactly CHAIN_LEN cycles. The bit presented on pat_in during the k-th of those cycles (k counted from 0) is loaded into cell k.
- R4: While the window is open, the chain value rises by one on each of exactly win_len functional cycles, wrapping modulo 2^CHAIN_LEN, with cell 0 as the LSB. A win_len of zero leaves the loaded value untouched.
- R5: Scan shifting and functional capture never happen in the same cycle. The chain holds its value whenever neither is active, including the halt cycle between the window and the unload.
- R6: so_valid is high for exactly CHAIN_LEN cycles. During the k-th of those cycles, so_bit carries the captured value of cell k.
- R7: mis_count equals the number of bit positions in which the captured chain differs from exp_image, where bit k of exp_image is compared with cell k.
- R8: first_fail is the lowest index k whose bit differs, or 0 when mis_count is zero.
- R9: done is high for exactly one cycle, right after the last unload shift, and busy falls in the next cycle. mis_count and first_fail then hold until the next accepted start.
- R10: A start request while busy is high is ignored. The run in progress ends with one done pulse and with results decided by its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, taken only when idle |
| mode_custom | input | 1 | 1: serial pattern start state, 0: reset start state |
| pat_in | input | 1 | Serial pattern bit, consumed when pat_take is high |
| win_len | input | WIN_W | Number of functional cycles in the window |
| exp_image | input | CHAIN_LEN | Expected captured image, bit k for cell k |
| pat_take | output | 1 | pat_in is shifted into the chain at the next edge |
| so_bit | output | 1 | Serial scan-out (cell 0) |
| so_valid | output | 1 | so_bit is an unload bit being compared |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when results are final |
| mis_count | output | $clog2(CHAIN_LEN+1) | Number of mismatching bits |
| first_fail | output | $clog2(CHAIN_LEN) | Lowest failing chain index |

## Verification
The assertions assume that exp_image and win_len are valid when a start is accepted, and that exp_image does not change for the rest of the run. They also assume that pat_in is sampled only in cycles where pat_take is high. The bench applies every setting and the start pulse on the falling edge before the run. It holds exp_image constant until done has been seen, and drives pat_in only while pat_take is high. Start requests made in the middle of a run use the opposite mode. If the block failed to ignore them, the observed image would be wrong.

// File: rtl/scan_upset_pkg.sv
package scan_upset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET_INIT,
    ST_SCAN_LOAD,
    ST_RUN,
    ST_HALT,
    ST_SCAN_UNLOAD,
    ST_DONE
  } seq_state_e;

  // True on the final step of a phase that lasts len steps.
  function automatic logic hit_last(input logic [31:0] cnt, input logic [31:0] len);
    return (cnt + 32'd1) == len;
  endfunction

endpackage

// File: rtl/uscan_cell.sv
module uscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic cap,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  // Mux-D scan cell: scan path has priority, functional capture is gated.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (se)  q <= d_scan;
    else if (cap) q <= d_func;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         se,
  input  logic         fce,
  input  logic         core_rst,
  input  logic         scan_in,
  output logic         scan_out,
  output logic [N-1:0] chain_q
);
  // Functional next state: binary increment, cell 0 is LSB.
  function automatic logic [N-1:0] func_step(input logic [N-1:0] v);
    return v + {{(N-1){1'b0}}, 1'b1};
  endfunction

  logic [N-1:0] next_val;
  logic [N-1:0] d_func;
  logic [N:0]   link;
  logic         cap;

  assign next_val = func_step(chain_q);
  assign d_func   = core_rst ? RESET_VAL : next_val;
  assign cap      = fce | core_rst;
  assign link[N]  = scan_in;
  assign scan_out = chain_q[0];

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign link[i] = chain_q[i];
    uscan_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .se     (se),
      .cap    (cap),
      .d_func (d_func[i]),
      .d_scan (link[i+1]),
      .q      (chain_q[i])
    );
  end
endmodule

// File: rtl/upset_seq_fsm.sv
module upset_seq_fsm
  import scan_upset_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned WIN_W = 16,
  localparam int unsigned NB    = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned CNT_W = (WIN_W > NB) ? WIN_W : NB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_custom,
  input  logic [WIN_W-1:0] win_len,
  output seq_state_e       state,
  output logic [NB-1:0]    shift_idx,
  output logic             launch,
  output logic             se,
  output logic             fce,
  output logic             core_rst,
  output logic             load_ph,
  output logic             unload_ph
);
  logic [CNT_W-1:0] cnt;
  logic [WIN_W-1:0] win_q;
  logic             last_chain;
  logic             last_win;
  logic             win_zero;

  assign last_chain = hit_last(32'(cnt), 32'(N));
  assign last_win   = hit_last(32'(cnt), 32'(win_q));
  assign win_zero   = (win_q == '0);

  assign launch    = (state == ST_IDLE) && start;
  assign load_ph   = (state == ST_SCAN_LOAD);
  assign unload_ph = (state == ST_SCAN_UNLOAD);
  assign se        = load_ph || unload_ph;
  assign fce       = (state == ST_RUN);
  assign core_rst  = (state == ST_RESET_INIT);
  assign shift_idx = cnt[NB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      win_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            win_q <= win_len;
            state <= mode_custom ? ST_SCAN_LOAD : ST_RESET_INIT;
          end
        end
        ST_RESET_INIT: begin
          cnt   <= '0;
          state <= win_zero ? ST_HALT : ST_RUN;
        end
        ST_SCAN_LOAD: begin
          if (last_chain) begin
            cnt   <= '0;
            state <= win_zero ? ST_HALT : ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (last_win) begin
            cnt   <= '0;
            state <= ST_HALT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HALT: begin
          cnt   <= '0;
          state <= ST_SCAN_UNLOAD;
        end
        ST_SCAN_UNLOAD: begin
          if (last_chain) begin
            cnt   <= '0;
            state <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unload_cmp.sv
module unload_cmp #(
  parameter int unsigned N = 8,
  localparam int unsigned NB = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned MW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cmp_en,
  input  logic [NB-1:0] idx,
  input  logic          so_bit,
  input  logic [N-1:0]  exp_image,
  output logic [MW-1:0] mis_count,
  output logic [NB-1:0] first_fail
);
  logic miss;
  assign miss = cmp_en && (so_bit != exp_image[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_count  <= '0;
      first_fail <= '0;
    end else if (clear) begin
      mis_count  <= '0;
      first_fail <= '0;
    end else if (miss) begin
      mis_count <= mis_count + 1'b1;
      if (mis_count == '0) first_fail <= idx;
    end
  end
endmodule

// File: rtl/scan_upset_ctrl.sv
module scan_upset_ctrl
  import scan_upset_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned WIN_W     = 16,
  parameter logic [CHAIN_LEN-1:0] RESET_VAL = CHAIN_LEN'('hA5),
  localparam int unsigned NB = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int unsigned MW = $clog2(CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode_custom,
  input  logic                 pat_in,
  input  logic [WIN_W-1:0]     win_len,
  input  logic [CHAIN_LEN-1:0] exp_image,
  output logic                 pat_take,
  output logic                 so_bit,
  output logic                 so_valid,
  output logic                 busy,
  output logic                 done,
  output logic [MW-1:0]        mis_count,
  output logic [NB-1:0]        first_fail
);
  seq_state_e           state_q;
  logic [NB-1:0]        shift_idx;
  logic                 launch_w;
  logic                 se_w;
  logic                 fce_w;
  logic                 core_rst_w;
  logic                 load_w;
  logic                 unload_w;
  logic                 scan_in_w;
  logic                 scan_out_w;
  logic [CHAIN_LEN-1:0] chain_q;

  upset_seq_fsm #(.N(CHAIN_LEN), .WIN_W(WIN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_custom (mode_custom),
    .win_len     (win_len),
    .state       (state_q),
    .shift_idx   (shift_idx),
    .launch      (launch_w),
    .se          (se_w),
    .fce         (fce_w),
    .core_rst    (core_rst_w),
    .load_ph     (load_w),
    .unload_ph   (unload_w)
  );

  // Pattern enters only during load; zeros fill in behind the unload.
  assign scan_in_w = load_w & pat_in;

  scan_chain #(.N(CHAIN_LEN), .RESET_VAL(RESET_VAL)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .se       (se_w),
    .fce      (fce_w),
    .core_rst (core_rst_w),
    .scan_in  (scan_in_w),
    .scan_out (scan_out_w),
    .chain_q  (chain_q)
  );

  unload_cmp #(.N(CHAIN_LEN)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (launch_w),
    .cmp_en     (unload_w),
    .idx        (shift_idx),
    .so_bit     (scan_out_w),
    .exp_image  (exp_image),
    .mis_count  (mis_count),
    .first_fail (first_fail)
  );

  assign pat_take = load_w;
  assign so_bit   = scan_out_w;
  assign so_valid = unload_w;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/upset_ctrl_chk.sv
module upset_ctrl_chk #(
  parameter int unsigned N = 8,
  localparam int unsigned NB = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned MW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          se,
  input logic          fce,
  input logic          core_rst,
  input logic [N-1:0]  chain_q,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pat_take,
  input logic          so_valid,
  input logic [MW-1:0] mis_count,
  input logic [NB-1:0] first_fail
);
  logic [MW:0] take_run;
  logic [MW:0] out_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_run <= '0;
      out_run  <= '0;
    end else begin
      take_run <= pat_take ? take_run + 1'b1 : '0;
      out_run  <= so_valid ? out_run + 1'b1 : '0;
    end
  end

  p_se_fce_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(se && (fce || core_rst)));

  p_chain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!se && !fce && !core_rst) |=> $stable(chain_q));

  p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pat_take) |-> (take_run == (MW+1)'(N)));

  p_unload_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(so_valid) |-> (out_run == (MW+1)'(N)));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid |=> (mis_count == $past(mis_count) || mis_count == $past(mis_count) + 1'b1));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mis_count <= MW'(N));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(mis_count) && $stable(first_fail)));

  p_start_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind scan_upset_ctrl upset_ctrl_chk #(.N(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .se         (se_w),
  .fce        (fce_w),
  .core_rst   (core_rst_w),
  .chain_q    (chain_q),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .pat_take   (pat_take),
  .so_valid   (so_valid),
  .mis_count  (mis_count),
  .first_fail (first_fail)
);

// File: tb/tb_scan_upset_ctrl.sv
module tb_scan_upset_ctrl;
  localparam int N      = 8;
  localparam int WIN_W  = 16;
  localparam int NB     = 3;
  localparam int MW     = 4;
  localparam int CLK_P  = 10;
  localparam logic [N-1:0] RV = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode_custom = 1'b0;
  logic pat_in = 1'b0;
  logic [WIN_W-1:0] win_len = '0;
  logic [N-1:0] exp_image = '0;
  logic pat_take, so_bit, so_valid, busy, done;
  logic [MW-1:0] mis_count;
  logic [NB-1:0] first_fail;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_P/2) clk = ~clk;

  scan_upset_ctrl #(.CHAIN_LEN(N), .WIN_W(WIN_W), .RESET_VAL(RV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_custom(mode_custom),
    .pat_in(pat_in), .win_len(win_len), .exp_image(exp_image),
    .pat_take(pat_take), .so_bit(so_bit), .so_valid(so_valid),
    .busy(busy), .done(done), .mis_count(mis_count), .first_fail(first_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // One full run; settings applied on a falling edge.
  task automatic do_run(input bit custom, input logic [N-1:0] pat, input int win,
                        input logic [N-1:0] expimg, input bit poke);
    logic [N-1:0] golden;
    logic [N-1:0] got;
    int ti;
    int ui;
    int exp_cnt;
    int exp_first;
    int guard;
    golden = (custom ? pat : RV) + N'(win);
    exp_cnt = 0;
    exp_first = 0;
    for (int k = N-1; k >= 0; k--) begin
      if (golden[k] != expimg[k]) begin
        exp_cnt++;
        exp_first = k;
      end
    end
    got = '0; ti = 0; ui = 0; guard = 0;
    @(negedge clk);
    mode_custom = custom;
    win_len = WIN_W'(win);
    exp_image = expimg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 2000) begin
      // R10: stray starts with the opposite mode while busy
      if (poke && guard < 2) begin start = 1'b1; mode_custom = ~custom; end
      else start = 1'b0;
      if (pat_take) begin pat_in = pat[ti % N]; ti++; end
      if (so_valid) begin got[ui % N] = so_bit; ui++; end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R9 done seen", int'(done), 1);
    check("R3 load shifts", ti, custom ? N : 0);
    check("R6 unload shifts", ui, N);
    check(custom ? "R3/R4 image" : "R2/R4 image", int'(got), int'(golden));
    check("R7 mis_count", int'(mis_count), exp_cnt);
    check("R8 first_fail", int'(first_fail), exp_first);
    @(negedge clk);
    check("R9 done one cycle", int'(done), 0);
    check("R9 busy low", int'(busy), 0);
    @(negedge clk);
    check("R9 count held", int'(mis_count), exp_cnt);
    check("R9 first held", int'(first_fail), exp_first);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 pat_take", int'(pat_take), 0);
    check("R1 so_valid", int'(so_valid), 0);
    check("R1 mis_count", int'(mis_count), 0);
    check("R1 first_fail", int'(first_fail), 0);
    rst_n = 1'b1;
    // R2/R4: reset-mode window sweep, including wrap
    for (int w = 0; w <= 40; w++) do_run(1'b0, '0, w, RV + N'(w), 1'b0);
    do_run(1'b0, '0, 300, RV + N'(300), 1'b0);
    do_run(1'b0, '0, 5, 8'h00, 1'b0);
    // R3/R7/R8: every custom pattern, window 0 identity and short windows
    for (int p = 0; p < 256; p++) begin
      logic [N-1:0] g;
      logic [N-1:0] m;
      g = N'(p) + N'(p % 7);
      m = ((p % 2) == 0) ? '0 : N'(p * 29 + 3);
      do_run(1'b1, N'(p), p % 7, g ^ m, (p % 16) == 5);
    end
    // R10: start while busy from reset mode
    do_run(1'b0, 8'h3C, 9, RV + 8'd9, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule